// File: doc/BRIEF.md
# Priority Transfer-Request Queue Arbiter

This block decides which of two requesters, a CPU and a memory-copy engine, gets the single external-memory port next. Each requester presents a one-cycle request together with a two-bit urgency code. An accepted request is held as a token in one of four bounded queues, one queue per urgency code. The block returns back-pressure to each requester through a ready signal.

The memory port serves one token at a time. When the port is free, the arbiter takes the oldest token from the most urgent non-empty queue. It then holds the port for a fixed number of clock cycles, set by a parameter. A start pulse marks the first cycle of an access and a done pulse marks its last. The next access may begin in the cycle right after done, so a waiting token follows with no idle gap. No data moves through the block; only request tokens and grant timing are modelled.

Top module: `xfer_req_arbiter`

## Requirements
- R1: There are four queues, one for each urgency code on `cpu_prio` / `cpy_prio`. Code 0 is the most urgent and code 3 the least.
- R2: Each queue holds at most QDEPTH (default 16) tokens. A requester's ready output is low while the queue its code selects is full. A request made while ready is low is dropped and never granted.
- R3: When both requesters request the same code in the same cycle, the CPU token enters ahead of the copy token. If only one slot is left, the CPU gets it and `cpy_ready` is low.
- R4: The copy engine can have a request accepted in every consecutive cycle while its queue has room.
- R5: Each grant takes the oldest token of the most urgent non-empty queue. `mem_src` gives the owner of the grant (0 = CPU, 1 = copy engine) and `mem_prio` gives its code.
- R6: An access raises `mem_start` for one cycle and keeps `mem_busy` high for exactly ACCESS_CYCLES cycles. `mem_done` pulses in the last of those cycles.
- R7: Accesses never overlap: a new `mem_start` comes only when the port is idle or in the cycle right after `mem_done`. When tokens are waiting, consecutive starts are exactly ACCESS_CYCLES cycles apart.
- R8: After reset all queues are empty, both ready outputs are high, and `mem_start`, `mem_busy` and `mem_done` are low.
- R9: A request accepted at a clock edge while the port is idle produces `mem_start` after the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | CPU request, one token per cycle it is high with ready |
| cpu_prio | input | 2 | CPU urgency code, 0 most urgent |
| cpu_ready | output | 1 | CPU token can be accepted this cycle |
| cpy_req | input | 1 | Copy-engine request |
| cpy_prio | input | 2 | Copy-engine urgency code |
| cpy_ready | output | 1 | Copy token can be accepted this cycle |
| mem_start | output | 1 | First cycle of a memory access |
| mem_busy | output | 1 | Memory port occupied |
| mem_done | output | 1 | Last cycle of a memory access |
| mem_src | output | 1 | Owner of the current access, 0 CPU, 1 copy |
| mem_prio | output | 2 | Urgency code of the current access |

## Verification
The checker watches on every cycle that no queue count goes past QDEPTH and that a refused request leaves its queue unchanged. It also checks the CPU-first split of the last free slot, that no less urgent code is granted while a more urgent queue holds tokens, and that accesses last exactly ACCESS_CYCLES cycles without overlap. FIFO order within a queue, the full grant sequence for a mixed burst of requests, the two-edge latency from idle, and the fact that dropped requests never reach the port can only be shown by the bench scenarios. The bench compares each grant against an expected list built from the requirements.

// File: rtl/xfer_arb_pkg.sv
// Shared definitions for the transfer-request arbiter.
// Assumes exactly two requesters; the level count sets the code width.
package xfer_arb_pkg;
    localparam int NUM_LEVELS = 4;
    localparam int LEVEL_W    = $clog2(NUM_LEVELS);

    typedef enum logic {
        SRC_CPU  = 1'b0,
        SRC_COPY = 1'b1
    } src_e;
endpackage

// File: rtl/xfer_level_fifo.sv
// One urgency level's token queue. Accepts up to two tokens per cycle
// (port A is written ahead of port B) and releases at most one.
// Assumes DEPTH is a power of two, the caller never overfills it and
// never pops it empty.
module xfer_level_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 1,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_a,
    input  logic [W-1:0]  data_a,
    input  logic          push_b,
    input  logic [W-1:0]  data_b,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr, wr_b;

    // Slot for port B: right after port A's slot when both write.
    always_comb wr_b = push_a ? PW'(wr_ptr + PW'(1)) : wr_ptr;

    // Token storage write.
    always_ff @(posedge clk) begin
        if (push_a) store[wr_ptr] <= data_a;
        if (push_b) store[wr_b]   <= data_b;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= PW'(wr_ptr + PW'(push_a) + PW'(push_b));
            rd_ptr <= PW'(rd_ptr + PW'(pop));
            count  <= CW'(count + CW'(push_a) + CW'(push_b) - CW'(pop));
        end
    end

    assign head = store[rd_ptr];
endmodule

// File: rtl/xfer_level_pick.sv
// Chooses the most urgent non-empty level (lowest index wins).
// Pure combinational; the caller qualifies the pop vector with launch.
module xfer_level_pick #(
    parameter int LEVELS = 4,
    localparam int LW    = $clog2(LEVELS)
) (
    input  logic [LEVELS-1:0] nonempty,
    output logic              valid,
    output logic [LW-1:0]     level,
    output logic [LEVELS-1:0] sel
);
    // Scan from least to most urgent so the lowest index is kept.
    always_comb begin
        level = '0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (nonempty[i]) level = LW'(i);
        end
        valid = |nonempty;
        sel   = valid ? (LEVELS'(1) << level) : '0;
    end
endmodule

// File: rtl/xfer_port_timer.sv
// Holds the memory port for ACC cycles per access and reports start,
// busy and done. Assumes ACC >= 1 and launch only when can_launch is high.
module xfer_port_timer #(
    parameter int ACC = 6,
    parameter int LW  = 2,
    localparam int TW = $clog2(ACC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          l_src,
    input  logic [LW-1:0] l_prio,
    output logic          can_launch,
    output logic          start,
    output logic          busy,
    output logic          done,
    output logic          src,
    output logic [LW-1:0] prio
);
    logic [TW-1:0] left;

    always_comb begin
        busy       = (left != '0);
        done       = (left == TW'(1));
        can_launch = !busy || done;
    end

    // Reload on launch, otherwise count the access down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left  <= '0;
            start <= 1'b0;
            src   <= 1'b0;
            prio  <= '0;
        end else begin
            start <= launch;
            if (launch) begin
                left <= TW'(ACC);
                src  <= l_src;
                prio <= l_prio;
            end else if (busy) begin
                left <= TW'(left - TW'(1));
            end
        end
    end
endmodule

// File: rtl/xfer_req_arbiter.sv
// Arbitrates one memory port between a CPU and a copy engine through
// per-urgency token queues. CPU wins ties for queue slots; the most
// urgent non-empty queue is served, FIFO within a level, one access
// of ACCESS_CYCLES cycles at a time.
module xfer_req_arbiter
    import xfer_arb_pkg::*;
#(
    parameter int QDEPTH        = 16,
    parameter int ACCESS_CYCLES = 6,
    localparam int CW           = $clog2(QDEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic [LEVEL_W-1:0] cpu_prio,
    output logic               cpu_ready,
    input  logic               cpy_req,
    input  logic [LEVEL_W-1:0] cpy_prio,
    output logic               cpy_ready,
    output logic               mem_start,
    output logic               mem_busy,
    output logic               mem_done,
    output logic               mem_src,
    output logic [LEVEL_W-1:0] mem_prio
);
    logic [NUM_LEVELS-1:0][CW-1:0] q_cnt;
    logic [NUM_LEVELS-1:0]         q_head;
    logic [NUM_LEVELS-1:0]         q_nonempty, q_sel;
    logic                          pick_valid, can_launch, launch;
    logic [LEVEL_W-1:0]            pick_level;
    logic                          cpu_take, cpy_take, same_lvl;

    // Back-pressure: CPU claims the last slot on a shared level.
    always_comb begin
        same_lvl  = cpu_req && (cpu_prio == cpy_prio);
        cpu_ready = (q_cnt[cpu_prio] != CW'(QDEPTH));
        cpy_ready = (q_cnt[cpy_prio] != CW'(QDEPTH)) &&
                    !(same_lvl && q_cnt[cpy_prio] == CW'(QDEPTH - 1));
        cpu_take  = cpu_req && cpu_ready;
        cpy_take  = cpy_req && cpy_ready;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_LEVELS; g++) begin : g_level
            xfer_level_fifo #(.DEPTH(QDEPTH), .W(1)) u_q (
                .clk    (clk),
                .rst_n  (rst_n),
                .push_a (cpu_take && cpu_prio == LEVEL_W'(g)),
                .data_a (SRC_CPU),
                .push_b (cpy_take && cpy_prio == LEVEL_W'(g)),
                .data_b (SRC_COPY),
                .pop    (launch && q_sel[g]),
                .head   (q_head[g]),
                .count  (q_cnt[g])
            );
            assign q_nonempty[g] = (q_cnt[g] != '0);
        end
    endgenerate

    xfer_level_pick #(.LEVELS(NUM_LEVELS)) u_pick (
        .nonempty (q_nonempty),
        .valid    (pick_valid),
        .level    (pick_level),
        .sel      (q_sel)
    );

    assign launch = pick_valid && can_launch;

    xfer_port_timer #(.ACC(ACCESS_CYCLES), .LW(LEVEL_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .l_src      (q_head[pick_level]),
        .l_prio     (pick_level),
        .can_launch (can_launch),
        .start      (mem_start),
        .busy       (mem_busy),
        .done       (mem_done),
        .src        (mem_src),
        .prio       (mem_prio)
    );
endmodule

// File: rtl/xfer_req_arbiter_chk.sv
// Property checker for xfer_req_arbiter, attached by bind below.
// Observes ports plus the per-level occupancy counts.
module xfer_req_arbiter_chk #(
    parameter int LEVELS = 4,
    parameter int DEPTH  = 16,
    parameter int ACC    = 6,
    parameter int LW     = 2,
    parameter int CW     = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LEVELS-1:0][CW-1:0] q_cnt,
    input logic                    cpu_req,
    input logic [LW-1:0]           cpu_prio,
    input logic                    cpu_ready,
    input logic                    cpy_req,
    input logic [LW-1:0]           cpy_prio,
    input logic                    cpy_ready,
    input logic                    mem_start,
    input logic                    mem_busy,
    input logic                    mem_done,
    input logic [LW-1:0]           mem_prio
);
    logic [LEVELS-1:0][CW-1:0] prev_cnt;
    int unsigned run_q, idx;
    logic urgent_waiting;

    // Occupancy one cycle back, for the grant-order check.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_cnt <= '0;
        else        prev_cnt <= q_cnt;
    end

    // Cycle index inside the current access.
    always_comb idx = mem_start ? 1 : run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= 0;
        else if (idx < ACC + 2) run_q <= idx + 1;
    end

    // Was any level more urgent than the granted one holding tokens?
    always_comb begin
        urgent_waiting = 1'b0;
        for (int i = 0; i < LEVELS; i++) begin
            if (LW'(i) < mem_prio && prev_cnt[i] != '0) urgent_waiting = 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_cap
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                q_cnt[g] <= CW'(DEPTH)); // R2
        end
    endgenerate

    AST_REFUSED_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ready && !(cpy_req && cpy_ready && cpy_prio == cpu_prio))
        |=> q_cnt[$past(cpu_prio)] <= $past(q_cnt[cpu_prio])); // R2

    AST_CPU_TAKES_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpy_req && cpu_prio == cpy_prio &&
         q_cnt[cpu_prio] == CW'(DEPTH - 1)) |-> (cpu_ready && !cpy_ready)); // R3

    AST_URGENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |-> !urgent_waiting); // R5

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |-> mem_busy); // R6

    AST_ACCESS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_done |-> (idx == ACC && mem_busy)); // R6

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |-> $past(!mem_busy || mem_done)); // R7
endmodule

bind xfer_req_arbiter xfer_req_arbiter_chk #(
    .LEVELS (xfer_arb_pkg::NUM_LEVELS),
    .DEPTH  (QDEPTH),
    .ACC    (ACCESS_CYCLES),
    .LW     (xfer_arb_pkg::LEVEL_W),
    .CW     (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_cnt     (q_cnt),
    .cpu_req   (cpu_req),
    .cpu_prio  (cpu_prio),
    .cpu_ready (cpu_ready),
    .cpy_req   (cpy_req),
    .cpy_prio  (cpy_prio),
    .cpy_ready (cpy_ready),
    .mem_start (mem_start),
    .mem_busy  (mem_busy),
    .mem_done  (mem_done),
    .mem_prio  (mem_prio)
);

// File: tb/sim_xfer_req_arbiter.sv
`timescale 1ns/1ps
module sim_xfer_req_arbiter;
    localparam int DEPTH = 16;
    localparam int ACC   = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpy_req = 1'b0;
    logic [1:0] cpu_prio = '0, cpy_prio = '0;
    logic       cpu_ready, cpy_ready;
    logic       mem_start, mem_busy, mem_done, mem_src;
    logic [1:0] mem_prio;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    int last_start = 0;
    bit have_prev = 0;
    bit spacing_on = 0;
    bit finished = 0;
    logic [2:0] exp_q [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    xfer_req_arbiter #(.QDEPTH(DEPTH), .ACCESS_CYCLES(ACC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_prio(cpu_prio), .cpu_ready(cpu_ready),
        .cpy_req(cpy_req), .cpy_prio(cpy_prio), .cpy_ready(cpy_ready),
        .mem_start(mem_start), .mem_busy(mem_busy), .mem_done(mem_done),
        .mem_src(mem_src), .mem_prio(mem_prio)
    );

    task automatic check(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Expected grant: {src, prio}, src 0 = CPU, 1 = copy.
    task automatic expect_grant(bit src, int prio);
        exp_q.push_back({src, 2'(prio)});
    endtask

    // Apply one cycle of requests; report the ready values seen before the edge.
    task automatic drive(bit cr, int cp, bit yr, int yp, output bit cok, output bit yok);
        cpu_req = cr; cpu_prio = 2'(cp);
        cpy_req = yr; cpy_prio = 2'(yp);
        #1;
        cok = cpu_ready; yok = cpy_ready;
        @(negedge clk);
        cpu_req = 1'b0; cpy_req = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || mem_busy) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    // Monitor: compare every grant with the scoreboard (R5) and its spacing (R7).
    always @(negedge clk) begin
        if (rst_n && mem_start) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected grant", {mem_src, mem_prio}, -1);
            end else begin
                logic [2:0] want;
                want = exp_q.pop_front();
                check({mem_src, mem_prio} == want, "R5 grant src/prio",
                      {mem_src, mem_prio}, want);
            end
            if (spacing_on && have_prev)
                check(cyc - last_start == ACC, "R7 back-to-back spacing",
                      cyc - last_start, ACC);
            last_start = cyc;
            have_prev  = 1'b1;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        bit cok, yok;
        int busy_len, done_at;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(cpu_ready == 1'b1, "R8 cpu_ready in reset", cpu_ready, 1);
        check(cpy_ready == 1'b1, "R8 cpy_ready in reset", cpy_ready, 1);
        check({mem_start, mem_busy, mem_done} == 3'b000, "R8 port idle in reset",
              {mem_start, mem_busy, mem_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 / R6: single CPU request from idle
        expect_grant(0, 2);
        drive(1, 2, 0, 0, cok, yok);
        check(mem_start == 1'b0, "R9 no start after first edge", mem_start, 0);
        @(negedge clk);
        check(mem_start == 1'b1, "R9 start after second edge", mem_start, 1);
        busy_len = 0; done_at = 0;
        while (mem_busy) begin
            busy_len++;
            if (mem_done) done_at = busy_len;
            @(negedge clk);
        end
        check(busy_len == ACC, "R6 busy length", busy_len, ACC);
        check(done_at == ACC, "R6 done in last busy cycle", done_at, ACC);
        repeat (3) @(negedge clk);

        // R1 / R3 / R5 / R7: mixed burst queued behind a running access
        spacing_on = 1'b1; have_prev = 1'b0;
        expect_grant(0, 3);
        drive(1, 3, 0, 0, cok, yok);
        expect_grant(1, 0);
        expect_grant(0, 1);
        expect_grant(1, 1);
        expect_grant(0, 2);
        expect_grant(1, 3);
        drive(1, 1, 1, 1, cok, yok);
        drive(0, 0, 1, 0, cok, yok);
        drive(1, 2, 1, 3, cok, yok);
        drain();
        check(exp_q.size() == 0, "R1 all burst grants seen", exp_q.size(), 0);

        // R2 / R3 / R4: fill level 2 from the copy engine
        have_prev = 1'b0;
        expect_grant(0, 3);
        drive(1, 3, 0, 0, cok, yok);
        for (int i = 0; i < DEPTH - 1; i++) begin
            expect_grant(1, 2);
            drive(0, 0, 1, 2, cok, yok);
            check(yok == 1'b1, "R4 copy accepted each cycle", yok, 1);
        end
        expect_grant(0, 2);
        drive(1, 2, 1, 2, cok, yok);
        check(cok == 1'b1, "R3 cpu gets last slot", cok, 1);
        check(yok == 1'b0, "R3 copy refused on last slot", yok, 0);
        drive(0, 1, 1, 2, cok, yok);
        check(yok == 1'b0, "R2 copy refused while full", yok, 0);
        check(cok == 1'b1, "R2 other level still ready", cok, 1);
        drain();
        check(exp_q.size() == 0, "R2 refused request never granted", exp_q.size(), 0);
        check(cpy_ready == 1'b1, "R2 ready again after drain", cpy_ready, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule